// File: doc/BRIEF.md
# ATM Transmit Filler Cell Inserter

This block sits on the transmit side of an ATM port, between the transmit cell buffer and the line-side framer. Each cycle in which the line asks for an octet (`tx_en` high), it puts out exactly one octet of a continuous stream of 53-octet cells. At the first octet of every cell slot it checks the buffer. If the buffer holds a cell, that cell is read out octet by octet and forwarded. If the buffer is empty, the block makes up a filler cell so that the line cell rate does not depend on the offered load.

Two kinds of filler can be selected: idle cells and unassigned cells. Both are built from a small configuration register. The register supplies the upper nibble of the first header octet and the lower nibble of the fourth header octet, and every other header bit is zero. The header error check position is sent as zero and a later stage fills it in. The 48 payload octets carry a fixed pad pattern. The block counts the filler cells it has inserted.

Top module: `iuc_inserter`

## Requirements
- R1: After a synchronous active-low reset, `out_valid`, `out_soc`, `out_fill` and `fill_count` are 0. The configuration is upper nibble 0000, lower nibble 0001 and idle mode, so the first filler header is 00 00 00 01 00.
- R2: When `tx_en` is low, `buf_rd` is low in that cycle, `out_valid` is low one cycle later, and the position within the cell does not advance.
- R3: If `buf_empty` is high on the first-octet cycle of a slot, the block sends a filler cell (`out_fill` high) and holds `buf_rd` low for all 53 octets of that cell.
- R4: If `buf_empty` is low on the first-octet cycle of a slot, `buf_rd` is high on each of the 53 octet cycles of that cell. `out_data` equals the `buf_data` value of the previous cycle, with `out_fill` low.
- R5: The choice between a real cell and a filler cell is made only on the first-octet cycle. Changes of `buf_empty` inside a cell change neither the cell type nor the `buf_rd` pattern.
- R6: `out_soc` is high on the first octet of each cell and on no other octet. Consecutive markers are exactly 53 valid octets apart.
- R7: Filler header octets in output order are: {upper nibble, 0000}, 0x00, 0x00, {0000, lower nibble}, then 0x00 in the header check position.
- R8: In unassigned mode, bit 0 of the fourth filler header octet is forced to 0. In idle mode the lower nibble is sent unchanged.
- R9: The 48 payload octets of a filler cell are all 0x6A.
- R10: A write (`cfg_wr` high) loads `cfg_wdata[3:0]` as the lower nibble, `cfg_wdata[7:4]` as the upper nibble and `cfg_wdata[8]` as the mode (1 = unassigned). The new value first takes effect on a cell whose first octet comes after the write cycle. A cell already started, including one starting in the write cycle, keeps its old header.
- R11: `fill_count` increments by one, wrapping modulo 2^CNT_W, in the same cycle as the first octet of each filler cell is output. It holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 9 | {mode, upper nibble, lower nibble} |
| tx_en | input | 1 | Line requests one octet this cycle |
| buf_empty | input | 1 | Transmit buffer holds no complete cell |
| buf_data | input | 8 | Buffer octet, valid in the cycle `buf_rd` is high |
| buf_rd | output | 1 | Buffer octet consumed this cycle |
| out_valid | output | 1 | `out_data` carries an octet |
| out_soc | output | 1 | First octet of a cell |
| out_fill | output | 1 | Octet belongs to a filler cell |
| out_data | output | 8 | Outgoing octet |
| fill_count | output | CNT_W | Number of filler cells inserted, wrapping |

## Verification
Two functions can land on the same cycle. The first is a configuration write and the cell-boundary decision that snapshots the header. The second is a change of `buf_empty` and the first-octet sample that fixes the cell type. The bench provokes the first directly, writing on the first-octet cycle of a filler cell and again in the middle of one. Random writes and random buffer-flag toggles, including some on the boundary cycle itself, provoke both further. A reference model judges each case. It snapshots the register only on the boundary and applies writes after that decision, so an early or late effect shows up as a wrong header octet or a wrong fill flag.

// File: rtl/iuc_pkg.sv
// Shared types for the filler cell inserter.
// Assumes a 9-bit configuration word laid out as {mode, upper nibble, lower nibble}.
package iuc_pkg;

    // Programmable header fields of a filler cell.
    typedef struct packed {
        logic       unassigned;  // 1: unassigned cell, 0: idle cell
        logic [3:0] hi_nib;      // upper nibble of header octet 1
        logic [3:0] lo_nib;      // lower nibble of header octet 4
    } hdr_cfg_t;

    localparam int unsigned CFG_W = $bits(hdr_cfg_t);

    // Reset value: standard idle header 00 00 00 01.
    localparam hdr_cfg_t CFG_RESET = '{unassigned: 1'b0, hi_nib: 4'h0, lo_nib: 4'h1};

endpackage

// File: rtl/iuc_cfg_reg.sv
// Holds the programmable filler header fields.
// Assumes writes are single-cycle strobes; the value is visible one cycle after the write.
module iuc_cfg_reg
    import iuc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output hdr_cfg_t         cfg
);

    hdr_cfg_t cfg_q;

    // Load the register on a write strobe, restore the idle defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (wr) begin
            cfg_q <= hdr_cfg_t'(wdata);
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/iuc_slot_seq.sv
// Tracks the octet position inside the current cell slot and decides, at the
// slot boundary only, whether the slot carries a buffered cell or a filler.
// Assumes the buffer presents a whole cell once it deasserts its empty flag.
module iuc_slot_seq #(
    parameter int unsigned CELL_OCTETS = 53,
    localparam int unsigned IDX_W      = $clog2(CELL_OCTETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             buf_empty,
    output logic [IDX_W-1:0] idx,
    output logic             boundary,
    output logic             cur_fill,
    output logic             buf_rd
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_OCTETS - 1);

    logic [IDX_W-1:0] idx_q;
    logic             fill_q;

    assign boundary = (idx_q == '0);
    // Type of the current slot: sampled at the boundary, held afterwards.
    assign cur_fill = boundary ? buf_empty : fill_q;
    assign buf_rd   = tx_en & ~cur_fill;
    assign idx      = idx_q;

    // Advance the octet position and latch the slot type on each emitted octet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            fill_q <= 1'b0;
        end else if (tx_en) begin
            fill_q <= cur_fill;
            idx_q  <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end
    end

endmodule

// File: rtl/iuc_fill_gen.sv
// Produces the filler octet for a given position inside the cell.
// Header fields are snapshotted at the slot boundary so a mid-cell register
// write cannot alter a cell already started.
// Assumes HDR_OCTETS >= 5 and CELL_OCTETS > HDR_OCTETS.
module iuc_fill_gen
    import iuc_pkg::*;
#(
    parameter int unsigned CELL_OCTETS = 53,
    parameter int unsigned HDR_OCTETS  = 5,
    parameter logic [7:0]  PAD_BYTE    = 8'h6A,
    parameter logic [7:0]  HEC_BYTE    = 8'h00,
    localparam int unsigned IDX_W      = $clog2(CELL_OCTETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             boundary,
    input  logic [IDX_W-1:0] idx,
    input  hdr_cfg_t         live_cfg,
    output logic [7:0]       fill_byte
);

    localparam logic [IDX_W-1:0] IDX_GFC = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_PTI = IDX_W'(3);
    localparam logic [IDX_W-1:0] IDX_HEC = IDX_W'(HDR_OCTETS - 1);
    localparam logic [IDX_W-1:0] IDX_PAY = IDX_W'(HDR_OCTETS);

    hdr_cfg_t   snap_q;
    hdr_cfg_t   eff;
    logic [3:0] lo_eff;
    logic [7:0] hdr_byte [HDR_OCTETS];

    // Freeze the header fields at the first octet of each slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= CFG_RESET;
        end else if (capture) begin
            snap_q <= live_cfg;
        end
    end

    // First octet uses the live register, the rest of the cell the snapshot.
    assign eff    = boundary ? live_cfg : snap_q;
    // Unassigned cells always carry a cleared loss-priority bit.
    assign lo_eff = eff.unassigned ? {eff.lo_nib[3:1], 1'b0} : eff.lo_nib;

    // Build the header octets; every bit outside the two nibbles is zero.
    for (genvar g = 0; g < HDR_OCTETS; g++) begin : g_hdr
        if (g == 0) begin : g_gfc
            assign hdr_byte[g] = {eff.hi_nib, 4'h0};
        end else if (g == 3) begin : g_pti
            assign hdr_byte[g] = {4'h0, lo_eff};
        end else if (g == HDR_OCTETS - 1) begin : g_hec
            assign hdr_byte[g] = HEC_BYTE;
        end else begin : g_zero
            assign hdr_byte[g] = 8'h00;
        end
    end

    // Select the header octet or the pad pattern by position.
    always_comb begin
        fill_byte = PAD_BYTE;
        for (int i = 0; i < HDR_OCTETS; i++) begin
            if (idx == IDX_W'(i)) begin
                fill_byte = hdr_byte[i];
            end
        end
        if (idx >= IDX_PAY) begin
            fill_byte = PAD_BYTE;
        end
    end

    // Positions named for readability of the header layout.
    logic unused_pos;
    assign unused_pos = ^{IDX_GFC, IDX_PTI, IDX_HEC};

endmodule

// File: rtl/iuc_fill_cnt.sv
// Free-running count of inserted filler cells, wrapping at 2^CNT_W.
// Assumes inc is a single-cycle pulse per filler cell.
module iuc_fill_cnt #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_q;

    // Step the counter once per inserted filler cell.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (inc) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/iuc_inserter.sv
// Transmit-side cell rate decoupling: forwards buffered cells, or inserts
// idle/unassigned filler cells when the buffer is empty at a cell boundary.
// Assumes the buffer delivers buf_data in the same cycle buf_rd is high and
// that one octet leaves per cycle in which tx_en is high.
module iuc_inserter
    import iuc_pkg::*;
#(
    parameter int unsigned CELL_OCTETS = 53,
    parameter int unsigned HDR_OCTETS  = 5,
    parameter logic [7:0]  PAD_BYTE    = 8'h6A,
    parameter logic [7:0]  HEC_BYTE    = 8'h00,
    parameter int unsigned CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [8:0]       cfg_wdata,
    input  logic             tx_en,
    input  logic             buf_empty,
    input  logic [7:0]       buf_data,
    output logic             buf_rd,
    output logic             out_valid,
    output logic             out_soc,
    output logic             out_fill,
    output logic [7:0]       out_data,
    output logic [CNT_W-1:0] fill_count
);

    localparam int unsigned IDX_W = $clog2(CELL_OCTETS);

    hdr_cfg_t         live_cfg;
    logic [IDX_W-1:0] idx;
    logic             boundary;
    logic             cur_fill;
    logic [7:0]       fill_byte;
    logic             fill_start;

    iuc_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (live_cfg)
    );

    iuc_slot_seq #(
        .CELL_OCTETS (CELL_OCTETS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .buf_empty (buf_empty),
        .idx       (idx),
        .boundary  (boundary),
        .cur_fill  (cur_fill),
        .buf_rd    (buf_rd)
    );

    iuc_fill_gen #(
        .CELL_OCTETS (CELL_OCTETS),
        .HDR_OCTETS  (HDR_OCTETS),
        .PAD_BYTE    (PAD_BYTE),
        .HEC_BYTE    (HEC_BYTE)
    ) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (tx_en & boundary),
        .boundary  (boundary),
        .idx       (idx),
        .live_cfg  (live_cfg),
        .fill_byte (fill_byte)
    );

    assign fill_start = tx_en & boundary & cur_fill;

    iuc_fill_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fill_start),
        .count (fill_count)
    );

    // Register the outgoing octet and its markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
            out_fill  <= 1'b0;
            out_data  <= 8'h00;
        end else begin
            out_valid <= tx_en;
            out_soc   <= tx_en & boundary;
            out_fill  <= tx_en & cur_fill;
            if (tx_en) begin
                out_data <= cur_fill ? fill_byte : buf_data;
            end
        end
    end

endmodule

// File: rtl/iuc_inserter_chk.sv
// Protocol checker for iuc_inserter, attached by bind.
// Tracks the output octet position to judge cell length, type and padding.
module iuc_inserter_chk #(
    parameter int unsigned CELL_OCTETS = 53,
    parameter int unsigned HDR_OCTETS  = 5,
    parameter logic [7:0]  PAD_BYTE    = 8'h6A,
    parameter int unsigned CNT_W       = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_en,
    input logic             buf_rd,
    input logic             out_valid,
    input logic             out_soc,
    input logic             out_fill,
    input logic [7:0]       out_data,
    input logic [CNT_W-1:0] fill_count
);

    localparam int unsigned POS_W = $clog2(CELL_OCTETS) + 1;

    logic [POS_W-1:0] pos_q;
    logic             seen_q;
    logic             last_fill_q;

    // Count octets emitted since the last start-of-cell marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q       <= '0;
            seen_q      <= 1'b0;
            last_fill_q <= 1'b0;
        end else if (out_valid) begin
            pos_q       <= out_soc ? POS_W'(1) : pos_q + 1'b1;
            seen_q      <= seen_q | out_soc;
            last_fill_q <= out_fill;
        end
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && fill_count == '0));

    a_r2_no_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !buf_rd);

    a_r2_no_octet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !out_valid);

    a_r3_fill_not_read: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && buf_rd) |=> !out_fill);

    a_r5_whole_cell: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_soc && seen_q) |-> (out_fill == last_fill_q));

    a_r6_soc_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> out_valid);

    a_r6_cell_length: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen_q) |-> (out_soc == (pos_q == POS_W'(CELL_OCTETS))));

    a_r9_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_fill && !out_soc && seen_q && pos_q >= POS_W'(HDR_OCTETS))
            |-> (out_data == PAD_BYTE));

    a_r11_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_soc && out_fill) |-> (fill_count == CNT_W'($past(fill_count) + 1'b1)));

    a_r11_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_soc && out_fill) |-> $stable(fill_count));

endmodule

bind iuc_inserter iuc_inserter_chk #(
    .CELL_OCTETS (CELL_OCTETS),
    .HDR_OCTETS  (HDR_OCTETS),
    .PAD_BYTE    (PAD_BYTE),
    .CNT_W       (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .buf_rd     (buf_rd),
    .out_valid  (out_valid),
    .out_soc    (out_soc),
    .out_fill   (out_fill),
    .out_data   (out_data),
    .fill_count (fill_count)
);

// File: tb/iuc_inserter_tb.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// judged against a cycle model built from the requirements.
module iuc_inserter_tb;

    localparam int TB_CNT_W = 6;
    localparam int CELL     = 53;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                cfg_wr = 1'b0;
    logic [8:0]          cfg_wdata = '0;
    logic                tx_en = 1'b0;
    logic                buf_empty = 1'b1;
    logic [7:0]          buf_data = '0;
    logic                buf_rd;
    logic                out_valid;
    logic                out_soc;
    logic                out_fill;
    logic [7:0]          out_data;
    logic [TB_CNT_W-1:0] fill_count;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Model state.
    int         m_idx = 0;
    bit         m_fill = 1'b0;
    int         m_cnt = 0;
    logic [3:0] l_hi = 4'h0, l_lo = 4'h1, s_hi = 4'h0, s_lo = 4'h1;
    bit         l_un = 1'b0, s_un = 1'b0;

    always #4 clk = ~clk;

    iuc_inserter #(.CNT_W(TB_CNT_W)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .tx_en      (tx_en),
        .buf_empty  (buf_empty),
        .buf_data   (buf_data),
        .buf_rd     (buf_rd),
        .out_valid  (out_valid),
        .out_soc    (out_soc),
        .out_fill   (out_fill),
        .out_data   (out_data),
        .fill_count (fill_count)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected filler octet from the requirements (R7, R8, R9).
    function automatic logic [7:0] fb(input int idx, input logic [3:0] hi, input logic [3:0] lo, input bit un);
        if (idx == 0) return {hi, 4'h0};
        if (idx == 3) return {4'h0, un ? {lo[3:1], 1'b0} : lo};
        if (idx < 5)  return 8'h00;
        return 8'h6A;
    endfunction

    // One line cycle: drive, check the read strobe, predict, then check outputs.
    task automatic step(input bit en, input bit emp, input logic [7:0] d, input bit wr, input logic [8:0] wd);
        bit         e_soc, e_fill;
        logic [7:0] e_data;
        int         e_idx;
        bit         e_rd;
        string      tag;
        tx_en = en; buf_empty = emp; buf_data = d; cfg_wr = wr; cfg_wdata = wd;
        #1;
        e_rd = en && !((m_idx == 0) ? emp : m_fill);
        if (!en)             tag = "R2";
        else if (m_idx != 0) tag = "R5";
        else                 tag = emp ? "R3" : "R4";
        check(buf_rd == e_rd, tag, buf_rd, e_rd);
        e_soc = 0; e_fill = 0; e_data = 0; e_idx = 0;
        if (en) begin
            if (m_idx == 0) begin
                m_fill = emp;
                s_hi = l_hi; s_lo = l_lo; s_un = l_un;
                if (emp) m_cnt++;
            end
            e_idx  = m_idx;
            e_soc  = (m_idx == 0);
            e_fill = m_fill;
            e_data = m_fill ? fb(m_idx, s_hi, s_lo, s_un) : d;
            m_idx  = (m_idx == CELL - 1) ? 0 : m_idx + 1;
        end
        if (wr) {l_un, l_hi, l_lo} = wd;
        @(negedge clk);
        check(out_valid == en, "R2", out_valid, en);
        check(fill_count == TB_CNT_W'(m_cnt), "R11", fill_count, TB_CNT_W'(m_cnt));
        if (en) begin
            check(out_soc == e_soc, "R6", out_soc, e_soc);
            check(out_fill == e_fill, e_soc ? "R3" : "R5", out_fill, e_fill);
            if (!e_fill)                                     tag = "R4";
            else if ((e_idx == 0 || e_idx == 3) &&
                     {s_un, s_hi, s_lo} != {l_un, l_hi, l_lo}) tag = "R10";
            else if (e_idx == 3 && s_un)                     tag = "R8";
            else if (e_idx >= 5)                             tag = "R9";
            else                                             tag = "R7";
            check(out_data == e_data, tag, out_data, e_data);
        end else begin
            check(out_soc == 1'b0, "R2", out_soc, 0);
        end
    endtask

    task automatic cells(input int n, input bit emp);
        for (int i = 0; i < n * CELL; i++) step(1'b1, emp, 8'(i * 7 + 3), 1'b0, '0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state of the outputs.
        check(out_valid == 1'b0, "R1", out_valid, 0);
        check(out_soc == 1'b0, "R1", out_soc, 0);
        check(fill_count == '0, "R1", fill_count, 0);
        rst_n = 1'b1;
        // R1: first filler after reset carries the default idle header.
        for (int i = 0; i < CELL; i++) begin
            step(1'b1, 1'b1, 8'hFF, 1'b0, '0);
            if (i == 0) check(out_data == 8'h00, "R1", out_data, 8'h00);
            if (i == 3) check(out_data == 8'h01, "R1", out_data, 8'h01);
        end
        // R4: two back-to-back real cells.
        cells(2, 1'b0);
        // R5: buffer fills mid-way through a filler cell, then empties mid-way through a real cell.
        step(1'b1, 1'b1, 8'h11, 1'b0, '0);
        for (int i = 1; i < CELL; i++) step(1'b1, 1'b0, 8'(i), 1'b0, '0);
        step(1'b1, 1'b0, 8'h22, 1'b0, '0);
        for (int i = 1; i < CELL; i++) step(1'b1, i[0], 8'(i + 40), 1'b0, '0);
        // R2: line pauses inside and at the edge of cells.
        for (int i = 0; i < 2 * CELL + 10; i++) step(i[1], i[3], 8'(i), 1'b0, '0);
        while (m_idx != 0) step(1'b1, 1'b1, 8'h00, 1'b0, '0);
        // R10: write on the first octet of a filler cell; that cell keeps the old header.
        step(1'b1, 1'b1, 8'h00, 1'b1, {1'b1, 4'hA, 4'hF});
        for (int i = 1; i < CELL; i++) step(1'b1, 1'b1, 8'h00, 1'b0, '0);
        // R8: next cell is unassigned with header A0 00 00 0E 00.
        for (int i = 0; i < CELL; i++) begin
            step(1'b1, 1'b1, 8'h00, 1'b0, '0);
            if (i == 0) check(out_data == 8'hA0, "R8", out_data, 8'hA0);
            if (i == 3) check(out_data == 8'h0E, "R8", out_data, 8'h0E);
        end
        // R10: write in the middle of a filler cell, back to idle mode.
        for (int i = 0; i < CELL; i++) step(1'b1, 1'b1, 8'h00, i == 20, {1'b0, 4'h3, 4'h5});
        cells(1, 1'b1);
        // R11: enough filler cells to wrap the counter.
        cells(70, 1'b1);
        // Random traffic with a fixed seed.
        void'($urandom(32'h5EED1234));
        begin
            bit emp = 1'b1;
            for (int i = 0; i < 12000; i++) begin
                if ($urandom_range(0, 19) == 0) emp = ~emp;
                step($urandom_range(0, 99) < 85, emp, 8'($urandom),
                     $urandom_range(0, 199) == 0, 9'($urandom));
            end
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule